// File: doc/BRIEF.md
# SCL Low Time-out Watchdog

This block watches a two-wire serial bus for two kinds of stall. The first is a clock line held low by some device for too long, which it reports as a fatal bus error. The second is a bus that has been claimed by a START but then shows no clock activity at all. When a local START request is waiting, that second case is reported so the bus controller can take the bus by force. One down-counter covers both cases, and every transition of the clock line reloads it.

Software programs an 8-bit control value. Bit 7 turns the watchdog on. Bits 6:0 hold a period field `p`, and the time-out lasts `(p + 1)` units. A unit is `UNIT_TICKS` pulses of the `tick` input, which comes from a shared prescaler. Both bus lines pass through two synchronizer flops before any edge is detected. Once a stuck-clock error is raised it stays raised until the block is reset. While it is raised the block asks for its bus drivers to be released, raises an interrupt request and reports status code 90h. At all other times the status reads F8h.

Top module: `scl_timeout_wdog`

## Requirements
- R1: After reset, `irq`, `drv_release` and `force_start` are 0 and `err_status` reads 8'hF8.
- R2: With bit 7 of the control value at 0, a clock line held low for any length of time raises no error.
- R3: With bit 7 at 1, a clock line held low for `(p+1)*UNIT_TICKS` tick pulses sets `irq` and `drv_release` to 1 and `err_status` to 8'h90. `p` is bits 6:0 of the control value. The error shows within a few cycles of expiry and does not show before the period has run out.
- R4: Every rising or falling transition of the clock line reloads the counter. Low phases shorter than the period therefore never raise an error, however many of them occur.
- R5: Once raised, the error stays raised until reset. The clock line returning high does not clear it, and neither does a rewrite of the control value.
- R6: `force_start` rises when all of the following hold for a full period: the bus is busy, `start_pend` is 1, the clock is high and the clock line does not change. The bus counts as busy after a START, which is a falling data line while the clock is high.
- R7: `force_start` stays 0, or drops within a few cycles, when `start_pend` is 0. It also stays 0 when the bus is free, which is the case after a STOP: a rising data line while the clock is high.
- R8: The counter advances only in cycles where `tick` is 1. With `tick` held at 0, no expiry occurs.
- R9: Writing the control value while the watchdog is disabled clears any pending force request. After that write, `force_start` is 0 until a new full period has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control value |
| cfg_wdata | input | 8 | Control value: bit 7 enable, bits 6:0 period field |
| scl_in | input | 1 | Clock line as seen on the bus, asynchronous |
| sda_in | input | 1 | Data line as seen on the bus, asynchronous |
| start_pend | input | 1 | A local START request is waiting for the bus |
| tick | input | 1 | One-cycle prescaler pulse that advances the counter |
| force_start | output | 1 | Idle busy bus has timed out; START may be forced |
| irq | output | 1 | Interrupt request, set by the stuck-clock error |
| drv_release | output | 1 | Asks for the bus drivers to be released |
| err_status | output | 8 | 8'h90 after a stuck-clock error, otherwise 8'hF8 |

## Verification
The clock line is tried in four patterns: held low with the watchdog disabled, held low with it enabled, toggled with low phases shorter than the period, and held low with `tick` stopped. Together these separate a real expiry from a missing reload, from a counter that ignores the enable, and from one that counts clock cycles instead of ticks. The idle-bus path is tried on a busy bus with and without a pending START, and on a free bus after a STOP, which separates the force condition from the stuck-clock one. A control write while the watchdog is disabled shows whether a stale force request survives that write. Two period settings confirm that the window scales with the period field.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam logic [7:0] STAT_NONE      = 8'hF8;
    localparam logic [7:0] STAT_SCL_STUCK = 8'h90;

    typedef struct packed {
        logic [7:0] cfg;
        logic       busy;
        logic       err;
        logic       force_req;
    } wdog_state_t;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    logic [LINES-1:0] ff1_d, ff1_q, ff2_d, ff2_q, prv_d, prv_q;

    always_comb begin
        ff1_d = raw;
        ff2_d = ff1_q;
        prv_d = ff2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff1_q <= '1;
            ff2_q <= '1;
            prv_q <= '1;
        end else begin
            ff1_q <= ff1_d;
            ff2_q <= ff2_d;
            prv_q <= prv_d;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lvl[i]  = ff2_q[i];
        assign rise[i] = ff2_q[i] & ~prv_q[i];
        assign fall[i] = ~ff2_q[i] & prv_q[i];
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNTW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CNTW-1:0] load_val,
    input  logic            run,
    input  logic            tick,
    output logic            expire
);
    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (run && tick && cnt_q != '0) begin
            cnt_d  = cnt_q - 1'b1;
            expire = (cnt_q == CNTW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/scl_timeout_wdog.sv
module scl_timeout_wdog #(
    parameter int UNIT_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       start_pend,
    input  logic       tick,
    output logic       force_start,
    output logic       irq,
    output logic       drv_release,
    output logic [7:0] err_status
);
    import wdog_pkg::*;

    localparam int CNTW = $clog2(128 * UNIT_TICKS + 1);
    localparam logic [CNTW-1:0] UNIT_W = CNTW'(UNIT_TICKS);
    localparam int SCL = 1;
    localparam int SDA = 0;

    wdog_state_t st_d, st_q;
    logic [1:0]  lvl, rise, fall;
    logic        scl_edge, start_det, stop_det;
    logic        run, load, expire, en;
    logic [CNTW-1:0] load_val;

    wdog_sync #(.LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({scl_in, sda_in}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    always_comb begin
        en        = st_q.cfg[7];
        scl_edge  = rise[SCL] | fall[SCL];
        start_det = fall[SDA] & lvl[SCL];
        stop_det  = rise[SDA] & lvl[SCL];
        run       = en && !st_q.err && (!lvl[SCL] || (st_q.busy && start_pend));
        load      = cfg_we || scl_edge || !run;

        st_d = st_q;
        if (cfg_we) st_d.cfg = cfg_wdata;
        load_val = CNTW'({1'b0, st_d.cfg[6:0]} + 8'd1) * UNIT_W;

        if (start_det)     st_d.busy = 1'b1;
        else if (stop_det) st_d.busy = 1'b0;

        if (expire && !lvl[SCL]) st_d.err = 1'b1;

        if (!start_pend || !st_q.busy || scl_edge || st_q.err || (cfg_we && !en))
            st_d.force_req = 1'b0;
        else if (expire && lvl[SCL])
            st_d.force_req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: 8'h00, busy: 1'b0, err: 1'b0, force_req: 1'b0};
        else        st_q <= st_d;
    end

    wdog_counter #(.CNTW(CNTW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .run     (run),
        .tick    (tick),
        .expire  (expire)
    );

    assign force_start = st_q.force_req & en;
    assign irq         = st_q.err;
    assign drv_release = st_q.err;
    assign err_status  = st_q.err ? STAT_SCL_STUCK : STAT_NONE;

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
    // R2
    err_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> $past(st_q.cfg[7]));
    // R6
    force_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.force_req) |-> $past(st_q.busy) && $past(start_pend));
    // R8
    err_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> $past(tick));
endmodule

// File: tb/scl_timeout_wdog_tb.sv
module scl_timeout_wdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 2;

    typedef struct {
        string       tag;
        logic [10:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       scl_in = 1'b1, sda_in = 1'b1, start_pend = 1'b0, tick = 1'b1;
    logic       force_start, irq, drv_release;
    logic [7:0] err_status;

    item_t q[$];
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timeout_wdog #(.UNIT_TICKS(UNIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .scl_in(scl_in), .sda_in(sda_in), .start_pend(start_pend), .tick(tick),
        .force_start(force_start), .irq(irq), .drv_release(drv_release),
        .err_status(err_status)
    );

    function automatic logic [10:0] mk(input logic e, input logic f);
        return {e, e, f, e ? 8'h90 : 8'hF8};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic e, input logic f);
        item_t it;
        it.tag = tag;
        it.exp = mk(e, f);
        q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
    endtask

    // monitor: pops expectations a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        while (q.size() > 0) begin
            item_t it;
            logic [10:0] act;
            it  = q.pop_front();
            act = {irq, drv_release, force_start, err_status};
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset;
        expect_out("R1 reset state", 0, 0); cyc(2);

        // R2: disabled, clock held low
        wr(8'h03);
        scl_in = 1'b0; cyc(100);
        expect_out("R2 disabled no error", 0, 0); cyc(2);
        scl_in = 1'b1; cyc(5);

        // R4: period 8 ticks, low phases of 5 cycles
        wr(8'h83);
        for (int i = 0; i < 12; i++) begin
            scl_in = 1'b0; cyc(5);
            scl_in = 1'b1; cyc(5);
        end
        expect_out("R4 short low phases", 0, 0); cyc(2);

        // R8: no ticks, clock low long
        tick = 1'b0;
        scl_in = 1'b0; cyc(60);
        expect_out("R8 no tick no expiry", 0, 0); cyc(2);
        scl_in = 1'b1; cyc(5);
        tick = 1'b1; cyc(3);

        // R7: busy bus, no pending start
        sda_in = 1'b0; cyc(5);
        cyc(40);
        expect_out("R7 no start_pend", 0, 0); cyc(2);

        // R6: pending start on idle busy bus
        start_pend = 1'b1;
        cyc(5);
        expect_out("R6 before period", 0, 0); cyc(1);
        cyc(7);
        expect_out("R6 force after period", 0, 1); cyc(2);
        start_pend = 1'b0; cyc(4);
        expect_out("R7 drop on start_pend low", 0, 0); cyc(2);

        // R7: STOP frees the bus
        sda_in = 1'b1; cyc(5);
        start_pend = 1'b1; cyc(40);
        expect_out("R7 free bus no force", 0, 0); cyc(2);
        start_pend = 1'b0;

        // R9: pending force, disable, rewrite while disabled
        sda_in = 1'b0; cyc(5);
        start_pend = 1'b1; cyc(20);
        expect_out("R9 force pending", 0, 1); cyc(2);
        wr(8'h03);
        expect_out("R9 disabled gates force", 0, 0); cyc(1);
        wr(8'h83);
        cyc(1);
        expect_out("R9 write while disabled clears", 0, 0); cyc(2);
        start_pend = 1'b0; cyc(3);

        // R3: stuck clock, period 8 ticks
        scl_in = 1'b0;
        cyc(7);
        expect_out("R3 not before period", 0, 0); cyc(1);
        cyc(6);
        expect_out("R3 error after period", 1, 0); cyc(2);

        // R5: sticky
        scl_in = 1'b1; cyc(10);
        wr(8'h00); cyc(20);
        expect_out("R5 sticky error", 1, 0); cyc(2);

        // R1 again, then R3 with period field 0
        sda_in = 1'b1;
        do_reset;
        expect_out("R1 reset clears error", 0, 0); cyc(2);
        wr(8'h80);
        scl_in = 1'b0; cyc(10);
        expect_out("R3 shortest period", 1, 0); cyc(2);
        scl_in = 1'b1;

        cyc(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule